// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the hardwired control unit of a small multi-cycle processor. It moves a single instruction at a time through a fixed set of phases (fetch, decode, execute, memory access, write-back) and drives every control line of the surrounding datapath in each phase. The instruction register, register file, ALU, program counter and memories are outside the block. It only sees the 4-bit opcode held in the instruction register and the zero flag latched by the datapath.

The path through the phases depends on the instruction class, so cycle counts differ. An ALU operation takes 4 cycles, a load 5, a store 4, a branch 3, and a halt stops after 2 and stays stopped until reset. All control outputs are decoded from the current phase and the opcode. The phase register updates on the rising clock edge and is cleared to fetch by a synchronous, active-high reset.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer enters fetch. In the cycle after that edge the outputs show the fetch pattern.
- R2: Fetch asserts `mem_read`, `ir_write` and `pc_write` with `pc_src`=0, whatever the opcode input. The next cycle is decode, which drives every control output low.
- R3: Opcodes 0x2..0x9 are register ALU operations with `alu_op` = opcode−2 (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not, 6 shift left, 7 shift right). They visit fetch, decode, execute and write-back, for 4 cycles. In execute they drive `alu_op` with `flag_write`=1. In write-back they hold `alu_op`/`alu_src` and assert `reg_write` with `mem_to_reg`=0.
- R4: `alu_src`=1 selects the immediate and 0 selects the register. Opcode 0xA is add-immediate (`alu_op`=0) and opcode 0xB is load-immediate (`alu_op`=8, pass). Both follow the R3 path with `alu_src`=1, while opcodes 0x2..0x9 use `alu_src`=0.
- R5: Opcode 0x0 (load) takes 5 cycles. Execute and memory access drive `alu_op`=0 with `alu_src`=1, memory access asserts `mem_read`, and write-back asserts `reg_write` with `mem_to_reg`=1.
- R6: Opcode 0x1 (store) takes 4 cycles. Execute and memory access drive `alu_op`=0 with `alu_src`=1, memory access asserts `mem_write`, and it returns to fetch with no write-back.
- R7: Opcodes 0xC (taken if zero), 0xD (taken if not zero) and 0xE (always taken) take 3 cycles whether taken or not. In execute they drive `alu_op`=8 with `alu_src`=1. They assert `pc_src` and `pc_write` only when the condition holds on the `zero_flag` value present in that cycle.
- R8: Opcode 0xF (halt) leaves decode for a terminal state. From then on every output stays low, whatever the opcode and flag inputs, until reset.
- R9: `mem_read` and `mem_write` are never both high.
- R10: `flag_write` is high only in the execute cycle of opcodes 0x2..0xB.
- R11: A reset in the middle of an instruction abandons it, and the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| zero_flag | input | 1 | Latched zero flag from the datapath |
| alu_op | output | 4 | ALU function select |
| alu_src | output | 1 | ALU operand B: 0 register, 1 immediate |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| mem_to_reg | output | 1 | Write-back source: 0 ALU, 1 memory |
| pc_src | output | 1 | PC source: 0 increment, 1 target |
| pc_write | output | 1 | PC load enable |
| ir_write | output | 1 | Instruction register load enable |
| flag_write | output | 1 | Status flag update enable |

## Verification
Two events can fall in the same cycle: a branch's condition decision and a change of the zero flag. The bench provokes this by driving a fresh random `zero_flag` value on every cycle, including the very cycle a branch sits in execute. It judges `pc_src`/`pc_write` against the flag value present in that cycle only. A second collision is a reset landing in the memory-access phase of a load or in the halted state. This is judged by requiring the fetch pattern in the following cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int OP_W    = 4;
    localparam int ALUOP_W = 4;

    // Opcode map
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'h0;
    localparam logic [OP_W-1:0] OPC_STORE = 4'h1;
    localparam logic [OP_W-1:0] OPC_ALU_LO = 4'h2;
    localparam logic [OP_W-1:0] OPC_ALU_HI = 4'h9;
    localparam logic [OP_W-1:0] OPC_ADDI  = 4'hA;
    localparam logic [OP_W-1:0] OPC_LDI   = 4'hB;
    localparam logic [OP_W-1:0] OPC_BZ    = 4'hC;
    localparam logic [OP_W-1:0] OPC_BNZ   = 4'hD;
    localparam logic [OP_W-1:0] OPC_JMP   = 4'hE;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'hF;

    // ALU function codes
    localparam logic [ALUOP_W-1:0] ALU_ADD  = 4'h0;
    localparam logic [ALUOP_W-1:0] ALU_PASS = 4'h8;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_EXEC   = 3'd2,
        S_MEM    = 3'd3,
        S_WB     = 3'd4,
        S_HALT   = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        C_ALU, C_LOAD, C_STORE, C_BRANCH, C_HALT
    } iclass_e;

    typedef enum logic [1:0] {
        COND_ALWAYS, COND_ZERO, COND_NONZERO
    } cond_e;

    typedef struct packed {
        iclass_e            cls;
        logic [ALUOP_W-1:0] alu_fn;
        logic               use_imm;
        cond_e              cond;
    } decode_t;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic               alu_src;
        logic               reg_write;
        logic               mem_read;
        logic               mem_write;
        logic               mem_to_reg;
        logic               pc_src;
        logic               pc_write;
        logic               ir_write;
        logic               flag_write;
    } ctl_t;

    function automatic decode_t classify(input logic [OP_W-1:0] op);
        decode_t d;
        d.cls     = C_ALU;
        d.alu_fn  = ALU_ADD;
        d.use_imm = 1'b0;
        d.cond    = COND_ALWAYS;
        if (op == OPC_LOAD) begin
            d.cls = C_LOAD;
        end else if (op == OPC_STORE) begin
            d.cls = C_STORE;
        end else if (op >= OPC_ALU_LO && op <= OPC_ALU_HI) begin
            d.alu_fn = ALUOP_W'(op - OPC_ALU_LO);
        end else if (op == OPC_ADDI) begin
            d.use_imm = 1'b1;
        end else if (op == OPC_LDI) begin
            d.alu_fn  = ALU_PASS;
            d.use_imm = 1'b1;
        end else if (op == OPC_HALT) begin
            d.cls = C_HALT;
        end else begin
            d.cls  = C_BRANCH;
            d.cond = (op == OPC_BZ)  ? COND_ZERO :
                     (op == OPC_BNZ) ? COND_NONZERO : COND_ALWAYS;
        end
        return d;
    endfunction

    function automatic logic cond_met(input cond_e c, input logic z);
        case (c)
            COND_ZERO:    return z;
            COND_NONZERO: return !z;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
    import mcs_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output decode_t         dec
);
    always_comb dec = classify(opcode);
endmodule

// File: rtl/mcs_next_phase.sv
module mcs_next_phase
    import mcs_pkg::*;
(
    input  phase_e  phase,
    input  decode_t dec,
    output phase_e  phase_nx
);
    always_comb begin
        phase_nx = S_FETCH;
        case (phase)
            S_FETCH:  phase_nx = S_DECODE;
            S_DECODE: phase_nx = (dec.cls == C_HALT) ? S_HALT : S_EXEC;
            S_EXEC: begin
                case (dec.cls)
                    C_ALU:            phase_nx = S_WB;
                    C_LOAD, C_STORE:  phase_nx = S_MEM;
                    default:          phase_nx = S_FETCH;
                endcase
            end
            S_MEM:    phase_nx = (dec.cls == C_LOAD) ? S_WB : S_FETCH;
            S_WB:     phase_nx = S_FETCH;
            S_HALT:   phase_nx = S_HALT;
            default:  phase_nx = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mcs_ctl_gen.sv
module mcs_ctl_gen
    import mcs_pkg::*;
(
    input  phase_e  phase,
    input  decode_t dec,
    input  logic    zero_flag,
    output ctl_t    ctl
);
    logic taken;
    always_comb taken = cond_met(dec.cond, zero_flag);

    always_comb begin
        ctl = '0;
        case (phase)
            S_FETCH: begin
                ctl.mem_read = 1'b1;
                ctl.ir_write = 1'b1;
                ctl.pc_write = 1'b1;
            end
            S_EXEC: begin
                case (dec.cls)
                    C_ALU: begin
                        ctl.alu_op     = dec.alu_fn;
                        ctl.alu_src    = dec.use_imm;
                        ctl.flag_write = 1'b1;
                    end
                    C_LOAD, C_STORE: begin
                        ctl.alu_op  = ALU_ADD;
                        ctl.alu_src = 1'b1;
                    end
                    C_BRANCH: begin
                        ctl.alu_op   = ALU_PASS;
                        ctl.alu_src  = 1'b1;
                        ctl.pc_src   = taken;
                        ctl.pc_write = taken;
                    end
                    default: ;
                endcase
            end
            S_MEM: begin
                ctl.alu_op    = ALU_ADD;
                ctl.alu_src   = 1'b1;
                ctl.mem_read  = (dec.cls == C_LOAD);
                ctl.mem_write = (dec.cls == C_STORE);
            end
            S_WB: begin
                ctl.reg_write = 1'b1;
                if (dec.cls == C_LOAD) begin
                    ctl.mem_to_reg = 1'b1;
                end else begin
                    ctl.alu_op  = dec.alu_fn;
                    ctl.alu_src = dec.use_imm;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import mcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    opcode,
    input  logic               zero_flag,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               alu_src,
    output logic               reg_write,
    output logic               mem_read,
    output logic               mem_write,
    output logic               mem_to_reg,
    output logic               pc_src,
    output logic               pc_write,
    output logic               ir_write,
    output logic               flag_write
);
    phase_e  state_q;
    phase_e  state_nx;
    decode_t dec;
    ctl_t    ctl;

    mcs_classify u_classify (
        .opcode (opcode),
        .dec    (dec)
    );

    mcs_next_phase u_next (
        .phase    (state_q),
        .dec      (dec),
        .phase_nx (state_nx)
    );

    mcs_ctl_gen u_ctl (
        .phase     (state_q),
        .dec       (dec),
        .zero_flag (zero_flag),
        .ctl       (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_nx;
    end

    assign alu_op     = ctl.alu_op;
    assign alu_src    = ctl.alu_src;
    assign reg_write  = ctl.reg_write;
    assign mem_read   = ctl.mem_read;
    assign mem_write  = ctl.mem_write;
    assign mem_to_reg = ctl.mem_to_reg;
    assign pc_src     = ctl.pc_src;
    assign pc_write   = ctl.pc_write;
    assign ir_write   = ctl.ir_write;
    assign flag_write = ctl.flag_write;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
    import mcs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input phase_e          phase,
    input logic [OP_W-1:0] opcode,
    input logic            reg_write,
    input logic            mem_read,
    input logic            mem_write,
    input logic            pc_src,
    input logic            pc_write,
    input logic            ir_write,
    input logic            flag_write
);
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> ir_write);

    p_decode_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ir_write |=> !ir_write && !mem_read && !mem_write && !reg_write && !pc_write && !flag_write);

    p_wb_ends_r3: assert property (@(posedge clk) disable iff (rst)
        reg_write |=> ir_write);

    p_store_ends_r6: assert property (@(posedge clk) disable iff (rst)
        mem_write |=> ir_write);

    p_branch_ends_r7: assert property (@(posedge clk) disable iff (rst)
        pc_src |=> ir_write);

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == S_HALT) |=> (phase == S_HALT) && !ir_write && !pc_write);

    p_mem_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));

    p_flag_alu_r10: assert property (@(posedge clk) disable iff (rst)
        flag_write |-> (opcode >= OPC_ALU_LO && opcode <= OPC_LDI) && (phase == S_EXEC));
endmodule

bind mc_sequencer mcs_checker u_mcs_checker (
    .clk        (clk),
    .rst        (rst),
    .phase      (state_q),
    .opcode     (opcode),
    .reg_write  (reg_write),
    .mem_read   (mem_read),
    .mem_write  (mem_write),
    .pc_src     (pc_src),
    .pc_write   (pc_write),
    .ir_write   (ir_write),
    .flag_write (flag_write)
);

// File: tb/tb_mc_sequencer.sv
module tb_mc_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       zero_flag = 1'b0;
    logic [3:0] alu_op;
    logic       alu_src, reg_write, mem_read, mem_write, mem_to_reg;
    logic       pc_src, pc_write, ir_write, flag_write;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_sequencer dut (
        .clk(clk), .rst(rst), .opcode(opcode), .zero_flag(zero_flag),
        .alu_op(alu_op), .alu_src(alu_src), .reg_write(reg_write),
        .mem_read(mem_read), .mem_write(mem_write), .mem_to_reg(mem_to_reg),
        .pc_src(pc_src), .pc_write(pc_write), .ir_write(ir_write),
        .flag_write(flag_write)
    );

    function automatic logic [12:0] outs();
        return {alu_op, alu_src, reg_write, mem_read, mem_write, mem_to_reg,
                pc_src, pc_write, ir_write, flag_write};
    endfunction

    function automatic int exp_len(logic [3:0] op);
        if (op == 4'h0) return 5;
        if (op == 4'h1) return 4;
        if (op <= 4'hB) return 4;
        if (op <= 4'hE) return 3;
        return 2;
    endfunction

    function automatic string req_of(logic [3:0] op);
        if (op == 4'h0) return "R5";
        if (op == 4'h1) return "R6";
        if (op >= 4'hA && op <= 4'hB) return "R4";
        if (op <= 4'h9) return "R3";
        if (op <= 4'hE) return "R7";
        return "R8";
    endfunction

    // idx: 0 fetch, 1 decode, 2 execute, 3 and 4 the following phases
    function automatic logic [12:0] exp_ctl(logic [3:0] op, int idx, logic z);
        logic [3:0] a, fn;
        logic s, rw, mr, mw, m2r, ps, pw, iw, fw, t;
        a = 4'h0; s = 0; rw = 0; mr = 0; mw = 0; m2r = 0; ps = 0; pw = 0; iw = 0; fw = 0;
        if (idx == 0) begin
            mr = 1; pw = 1; iw = 1;
        end else if (op <= 4'h1) begin
            if (idx == 2 || idx == 3) s = 1;
            if (idx == 3) begin mr = (op == 4'h0); mw = (op == 4'h1); end
            if (idx == 4) begin rw = 1; m2r = 1; end
        end else if (op <= 4'hB) begin
            fn = (op == 4'hB) ? 4'h8 : (op == 4'hA) ? 4'h0 : 4'(op - 4'h2);
            if (idx == 2 || idx == 3) begin a = fn; s = (op >= 4'hA); end
            fw = (idx == 2);
            rw = (idx == 3);
        end else if (op <= 4'hE) begin
            if (idx == 2) begin
                t = (op == 4'hE) || (op == 4'hC && z) || (op == 4'hD && !z);
                a = 4'h8; s = 1; ps = t; pw = t;
            end
        end
        return {a, s, rw, mr, mw, m2r, ps, pw, iw, fw};
    endfunction

    task automatic check_vec(string req, logic [12:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b (op %h)", req, outs(), exp, opcode);
        end
    endtask

    task automatic check_bits(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Positioned one step after an edge with the sequencer in fetch.
    // zmode: 0 low, 1 high, 2 random every cycle.
    task automatic run_instr(logic [3:0] op, int zmode);
        logic [3:0] junk;
        junk = 4'($urandom);
        opcode = junk;
        zero_flag = (zmode == 2) ? 1'($urandom) : 1'(zmode);
        #1 check_vec("R2", exp_ctl(op, 0, zero_flag));
        for (int i = 1; i < exp_len(op); i++) begin
            tick();
            opcode = op;
            zero_flag = (zmode == 2) ? 1'($urandom) : 1'(zmode);
            #1;
            check_vec((i == 1) ? "R2" : req_of(op), exp_ctl(op, i, zero_flag));
            check_bits("R9", mem_read & mem_write, 1'b0);
            check_bits("R10", flag_write, (i == 2) && op >= 4'h2 && op <= 4'hB);
        end
        if (op != 4'hF) begin
            tick();
            opcode = 4'($urandom);
            #1 check_bits({req_of(op), " cycle count"}, ir_write, 1'b1);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        opcode = 4'($urandom);
        #1 check_vec("R1", exp_ctl(4'h0, 0, 1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        do_reset();

        // Directed: every non-halt opcode, flag low and high
        for (int op = 0; op < 15; op++) begin
            run_instr(4'(op), 0);
            run_instr(4'(op), 1);
        end

        // Halt: terminal state ignores opcode and flag
        run_instr(4'hF, 2);
        for (int i = 0; i < 6; i++) begin
            tick();
            opcode = 4'($urandom);
            zero_flag = 1'($urandom);
            #1 check_vec("R8", 13'h0);
        end
        do_reset();

        // Random mix with the zero flag changing every cycle
        for (int n = 0; n < 300; n++) begin
            run_instr(4'($urandom_range(0, 14)), 2);
        end

        // Reset landing in the memory phase of a load
        opcode = 4'h3;
        #1 check_vec("R2", exp_ctl(4'h0, 0, 1'b0));
        tick(); opcode = 4'h0;
        tick();
        tick();
        #1 check_bits("R11 mem phase", mem_read, 1'b1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1 check_vec("R11", exp_ctl(4'h0, 0, 1'b0));
        run_instr(4'hB, 2);

        // Halt again, then recovery through reset
        run_instr(4'hF, 0);
        tick();
        #1 check_vec("R8", 13'h0);
        do_reset();
        run_instr(4'h1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule